// File: doc/BRIEF.md
# Masked Frame Word Insertion Unit

This block places user-supplied bits into an outgoing stream of frame words. Each cycle a frame position counter presents the word index within the basic frame, the basic-frame index and the hyperframe index. The block answers that cycle with a per-byte flag showing which byte lanes of that word are reserved for control information. User logic then supplies a data word and a bit mask. They arrive a fixed number of cycles later: one cycle plus a configurable number of extra cycles. Every masked bit replaces the matching bit of the default frame word. Every unmasked bit passes the default word through.

The block also checks each byte lane. A lane is flagged when a mask bit would overwrite a control byte. A lane is also flagged when a mask bit would overwrite the synchronisation word, which is the first word of basic frame 0 of hyperframe 0. The flag comes out one cycle after the offending write, on a registered per-byte error output.

Within a word, bits [31:24] are the first byte on the line and bits [7:0] are the last. The default frame word is presented in the same cycle as the user data and mask that apply to it.

Top module: `frame_word_overlay`

## Requirements
- R1: The data, mask and default word presented in a cycle apply to the frame index presented 1 + EXTRA_LAT cycles earlier. With EXTRA_LAT = 0 this delay is exactly one cycle.
- R2: Each bit of `ins_data` whose `usr_mask` bit was 1 equals the matching bit of `usr_data`.
- R3: Each bit of `ins_data` whose `usr_mask` bit was 0 equals the matching bit of `dflt_data`.
- R4: `ins_data` and `ovl_err` are registered. They change one clock edge after the cycle in which the data and mask were presented.
- R5: `ctl_slot` is combinational from the index inputs. It is 4'b1000 when `idx_word` is 0, which marks byte [31:24] as the control byte. It is 4'b0000 for every other word index.
- R6: `ovl_err[b]` is 1 when any mask bit in byte lane b (bits 8b+7..8b) was set and the aligned index had lane b marked as a control byte.
- R7: When the aligned index is the frame start (`idx_word`, `idx_bf` and `idx_hf` all 0), `ovl_err[b]` is 1 for every lane b whose mask byte was non-zero.
- R8: `ovl_err[b]` returns to 0 in the next cycle when lane b has no overlap. A zero mask never raises an error.
- R9: Synchronous active-high reset clears `ins_data`, `ovl_err` and the alignment pipeline. For the first 1 + EXTRA_LAT cycles after reset, no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_word | input | 7 | Word index within the basic frame |
| idx_bf | input | 8 | Basic-frame index within the hyperframe |
| idx_hf | input | 8 | Hyperframe index |
| ctl_slot | output | 4 | Control byte lanes of the current word index (bit 3 = byte [31:24]) |
| dflt_data | input | 32 | Default frame word, aligned with the user data |
| usr_data | input | 32 | User data to insert |
| usr_mask | input | 32 | Per-bit insertion mask |
| ins_data | output | 32 | Merged frame word (registered) |
| ovl_err | output | 4 | Per-lane overlap error (registered) |

## Verification
The frame-start check is the hardest case to reach from the ports. The bench must present all-zero indices and then supply a non-zero mask exactly 1 + EXTRA_LAT cycles later. Any other offset tests a different index. The bench drives the index inputs directly. It walks a short frame so that the start recurs every few dozen cycles, and it switches between random, empty and full masks so that overlap and no-overlap cycles on both the control lane and the other lanes follow each other closely. Two instances with different extra latencies run from the same stimulus, each against a queue-delayed reference, so that an off-by-one alignment shows up in at least one of them.

// File: rtl/fwo_pkg.sv
package fwo_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LANES    = DATA_W / 8;
    localparam int unsigned WIDX_W   = 7;
    localparam int unsigned BFIDX_W  = 8;
    localparam int unsigned HFIDX_W  = 8;

    // Position information carried through the alignment pipeline
    typedef struct packed {
        logic             sof;   // frame start word
        logic [LANES-1:0] ctl;   // control byte lanes
    } fwo_tag_t;

    // One bit per byte lane: any mask bit set within that lane
    function automatic logic [LANES-1:0] lane_any(input logic [DATA_W-1:0] m);
        logic [LANES-1:0] r;
        for (int b = 0; b < LANES; b++) begin
            r[b] = |m[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/fwo_pos_decode.sv
module fwo_pos_decode
    import fwo_pkg::*;
#(
    parameter int unsigned CTL_WORD = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDX_W-1:0]  idx_word,
    input  logic [BFIDX_W-1:0] idx_bf,
    input  logic [HFIDX_W-1:0] idx_hf,
    output fwo_tag_t           tag
);

    logic is_ctl_word;
    assign is_ctl_word = (idx_word == WIDX_W'(CTL_WORD));

    // First byte on the line (top lane) is the control byte of the control word
    generate
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            if (b == LANES - 1) begin : g_first
                assign tag.ctl[b] = is_ctl_word;
            end else begin : g_rest
                assign tag.ctl[b] = 1'b0;
            end
        end
    endgenerate

    assign tag.sof = (idx_word == '0) && (idx_bf == '0) && (idx_hf == '0);

    AST_CTL_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tag.ctl)) else $error("ctl lanes not one-hot"); // R5

    AST_NONCTL_WORD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (idx_word != '0) |-> (tag.ctl == '0)) else $error("ctl on data word"); // R5

endmodule

// File: rtl/fwo_align_pipe.sv
module fwo_align_pipe
    import fwo_pkg::*;
#(
    parameter int unsigned EXTRA_LAT = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  fwo_tag_t tag_in,
    output fwo_tag_t tag_out
);

    localparam int unsigned DEPTH = EXTRA_LAT + 1;

    fwo_tag_t stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= tag_in;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign tag_out = stage_q[DEPTH-1];

    AST_HEAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stage_q[0] == $past(tag_in))) else $error("pipe head"); // R1

endmodule

// File: rtl/fwo_merge.sv
module fwo_merge
    import fwo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fwo_tag_t          tag,
    input  logic [DATA_W-1:0] dflt_data,
    input  logic [DATA_W-1:0] usr_data,
    input  logic [DATA_W-1:0] usr_mask,
    output logic [DATA_W-1:0] ins_data,
    output logic [LANES-1:0]  ovl_err
);

    logic [DATA_W-1:0] merged;
    logic [LANES-1:0]  mask_lane;
    logic [LANES-1:0]  guard_lane;
    logic [LANES-1:0]  hit;

    assign merged     = (dflt_data & ~usr_mask) | (usr_data & usr_mask);
    assign mask_lane  = lane_any(usr_mask);
    assign guard_lane = tag.ctl | {LANES{tag.sof}};
    assign hit        = mask_lane & guard_lane;

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_data <= '0;
            ovl_err  <= '0;
        end else begin
            ins_data <= merged;
            ovl_err  <= hit;
        end
    end

    AST_MASKED_TAKES_USER: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((ins_data ^ $past(usr_data)) & $past(usr_mask)) == '0))
        else $error("masked bit mismatch"); // R2

    AST_UNMASKED_TAKES_DFLT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((ins_data ^ $past(dflt_data)) & ~$past(usr_mask)) == '0))
        else $error("unmasked bit mismatch"); // R3

    AST_NO_ERR_WITHOUT_MASK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ovl_err & ~lane_any($past(usr_mask))) == '0))
        else $error("error without mask"); // R8

    AST_SOF_FLAGS_ALL: assert property (@(posedge clk) disable iff (rst)
        tag.sof |=> (ovl_err == lane_any($past(usr_mask))))
        else $error("frame start lanes"); // R7

endmodule

// File: rtl/frame_word_overlay.sv
module frame_word_overlay
    import fwo_pkg::*;
#(
    parameter int unsigned EXTRA_LAT = 2,
    parameter int unsigned CTL_WORD  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDX_W-1:0]  idx_word,
    input  logic [BFIDX_W-1:0] idx_bf,
    input  logic [HFIDX_W-1:0] idx_hf,
    output logic [LANES-1:0]   ctl_slot,
    input  logic [DATA_W-1:0]  dflt_data,
    input  logic [DATA_W-1:0]  usr_data,
    input  logic [DATA_W-1:0]  usr_mask,
    output logic [DATA_W-1:0]  ins_data,
    output logic [LANES-1:0]   ovl_err
);

    fwo_tag_t now_tag;
    fwo_tag_t aligned_tag;

    fwo_pos_decode #(.CTL_WORD(CTL_WORD)) u_decode (
        .clk      (clk),
        .rst      (rst),
        .idx_word (idx_word),
        .idx_bf   (idx_bf),
        .idx_hf   (idx_hf),
        .tag      (now_tag)
    );

    assign ctl_slot = now_tag.ctl;

    fwo_align_pipe #(.EXTRA_LAT(EXTRA_LAT)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .tag_in  (now_tag),
        .tag_out (aligned_tag)
    );

    fwo_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .tag       (aligned_tag),
        .dflt_data (dflt_data),
        .usr_data  (usr_data),
        .usr_mask  (usr_mask),
        .ins_data  (ins_data),
        .ovl_err   (ovl_err)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ins_data == '0 && ovl_err == '0)) else $error("reset state"); // R9

endmodule

// File: tb/tb_frame_word_overlay.sv
module tb_frame_word_overlay;

    typedef struct packed {
        logic       sof;
        logic [3:0] ctl;
    } ref_tag_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  idx_word = '0;
    logic [7:0]  idx_bf = '0;
    logic [7:0]  idx_hf = '0;
    logic [31:0] dflt_data = '0;
    logic [31:0] usr_data = '0;
    logic [31:0] usr_mask = '0;
    logic [3:0]  ctl_slot, ctl_slot0;
    logic [31:0] ins_data, ins_data0;
    logic [3:0]  ovl_err, ovl_err0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    frame_word_overlay #(.EXTRA_LAT(2)) dut (
        .clk(clk), .rst(rst), .idx_word(idx_word), .idx_bf(idx_bf), .idx_hf(idx_hf),
        .ctl_slot(ctl_slot), .dflt_data(dflt_data), .usr_data(usr_data),
        .usr_mask(usr_mask), .ins_data(ins_data), .ovl_err(ovl_err)
    );

    frame_word_overlay #(.EXTRA_LAT(0)) dut_l0 (
        .clk(clk), .rst(rst), .idx_word(idx_word), .idx_bf(idx_bf), .idx_hf(idx_hf),
        .ctl_slot(ctl_slot0), .dflt_data(dflt_data), .usr_data(usr_data),
        .usr_mask(usr_mask), .ins_data(ins_data0), .ovl_err(ovl_err0)
    );

    ref_tag_t q_l2[$];
    ref_tag_t q_l0[$];

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_err(input ref_tag_t t, input logic [31:0] m);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b] = (|m[8*b +: 8]) && (t.ctl[b] || t.sof);
        end
        return r;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w = 0, bf = 0, hf = 0;
        repeat (3) @(posedge clk);
        #1;
        check32("R9 reset ins_data", ins_data, 32'h0);
        check4 ("R9 reset ovl_err", ovl_err, 4'h0);
        check32("R9 reset ins_data l0", ins_data0, 32'h0);
        check4 ("R9 reset ovl_err l0", ovl_err0, 4'h0);
        // Pipelines start cleared: prefill the reference queues with empty tags
        for (int i = 0; i < 3; i++) q_l2.push_back('0);
        q_l0.push_back('0);

        for (int step = 0; step < 800; step++) begin
            ref_tag_t now_t, al2, al0;
            logic [31:0] m;
            int mode;
            @(negedge clk);
            rst = 1'b0;
            // index walk: 4 words per basic frame, 4 basic frames, 3 hyperframes
            idx_word = 7'(w);
            idx_bf   = 8'(bf);
            idx_hf   = 8'(hf);
            if (step >= 400 && step % 37 == 5) begin
                idx_word = 7'd0; idx_bf = 8'd0; idx_hf = 8'd0;   // forced frame start
            end
            w++;
            if (w == 4) begin w = 0; bf++; end
            if (bf == 4) begin bf = 0; hf++; end
            if (hf == 3) hf = 0;

            mode = (step / 100) % 4;
            case (mode)
                0: m = $urandom;
                1: m = 32'h0;                                   // empty mask
                2: m = 32'hFFFF_FFFF;                           // full mask
                default: m = ($urandom % 2) ? 32'h0100_0000 : 32'h0000_0080;
            endcase
            dflt_data = $urandom;
            usr_data  = $urandom;
            usr_mask  = m;

            now_t.ctl = (idx_word == 0) ? 4'b1000 : 4'b0000;
            now_t.sof = (idx_word == 0) && (idx_bf == 0) && (idx_hf == 0);
            #1;
            check4("R5 ctl_slot", ctl_slot, now_t.ctl);

            q_l2.push_back(now_t);
            q_l0.push_back(now_t);
            al2 = q_l2.pop_front();
            al0 = q_l0.pop_front();

            @(posedge clk);
            #1;
            check32("R1 R2 R3 R4 ins_data lat2", ins_data,
                    (dflt_data & ~usr_mask) | (usr_data & usr_mask));
            check4 ("R1 R6 R7 R8 R9 ovl_err lat2", ovl_err, exp_err(al2, usr_mask));
            check32("R1 R2 R3 R4 ins_data lat0", ins_data0,
                    (dflt_data & ~usr_mask) | (usr_data & usr_mask));
            check4 ("R1 R6 R7 R8 ovl_err lat0", ovl_err0, exp_err(al0, usr_mask));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule